// File: doc/BRIEF.md
# Shifting ALU execution unit with funnel mode

This block is the single-cycle datapath of a small packet-processing engine. Each issued instruction supplies two 32-bit operands, an operation code, a shift-control code and a fixed shift amount. In the normal mode the B operand first goes through a shifter or rotator, and the result then feeds one of fourteen ALU operations. In funnel mode the block joins A (upper half) and B (lower half) into a double-width word, shifts it right and keeps the lower half. The result and the sign, zero and carry-out codes are registered and appear one clock after issue.

Some operations depend on earlier instructions. The unit therefore keeps a small amount of history. The low shift-field bits of the previous instruction's A operand supply the indirect shift amounts. The carry-out of the previous instruction feeds the add-with-carry operation. A two-deep record of sign codes feeds the conditional add, which looks at the sign produced two instructions back. All of this history moves forward only on cycles where an instruction is issued.

Top module: `shift_alu_unit`

## Requirements
- R1: A synchronous reset drives `result`, `result_valid`, `cc_sign`, `cc_zero` and `cc_cout` to 0. It also clears the previous-A shift field, the stored carry and both sign-history entries, so the first add-with-carry adds no carry and the first conditional add passes B.
- R2: An instruction issued with `issue_valid` high in one cycle has its result and codes visible after the next rising edge, with `result_valid` high for that cycle. While `issue_valid` is low, `result` and all codes hold their values.
- R3: `alu_sel` codes for the non-arithmetic operations: 0 passes B, 1 gives ~B, 8 gives A&B, 9 gives ~A&B, 10 gives A&~B, 11 gives A|B, 12 gives A^B. Codes 14 and 15 also pass B.
- R4: Code 2 gives A+B. Code 4 gives A plus the low 8 bits of the shifted B. Code 5 gives A plus the low 16 bits of the shifted B. For each, carry-out is bit 32 of the sum.
- R5: Code 3 gives A+B plus the carry-out left by the previously issued instruction.
- R6: Code 6 gives A−B and code 7 gives B−A. Each is computed as X+~Y+1, so carry-out is 1 exactly when no borrow occurs.
- R7: Carry-out is 0 for every operation outside codes 2 to 7, and for every funnel-mode instruction.
- R8: Code 13 (conditional add) gives A+B when the sign code of the instruction issued two issues earlier was 1, and B otherwise.
- R9: The `shf_mode` codes act on B before the ALU: 0 none, 1 left shift, 2 right shift, 3 left rotate, 4 right rotate, each by `shf_amt`. Code 7 also means none, and an amount of 0 leaves B unchanged.
- R10: `shf_mode` 6 shifts B right by the low 5 bits of the previous instruction's A operand. Mode 5 shifts B left by 32 minus that field (modulo 32).
- R11: With `funnel_en` high, the result is the low 32 bits of {A,B} shifted right by `shf_amt`, or by the previous-A field when `shf_mode` is 6. For example, A=0x87654321, B=0xFEDCBA98 and a shift of 12 give 0x321FEDCB.
- R12: For every instruction, including funnel mode, `cc_sign` equals the result's top bit and `cc_zero` is 1 exactly when the result is 0.
- R13: Idle cycles leave the previous-A field and the sign and carry history unchanged, whatever the operand inputs do meanwhile.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| issue_valid | input | 1 | An instruction is issued this cycle |
| funnel_en | input | 1 | Select funnel (double-word right shift) mode |
| alu_sel | input | 4 | ALU operation code |
| shf_mode | input | 3 | B shift-control code |
| shf_amt | input | 5 | Fixed shift amount |
| a_opnd | input | 32 | A operand |
| b_opnd | input | 32 | B operand |
| result | output | 32 | Registered result |
| result_valid | output | 1 | Result and codes updated on the last edge |
| cc_sign | output | 1 | Sign code |
| cc_zero | output | 1 | Zero code |
| cc_cout | output | 1 | Carry-out code |

## Verification
The bench builds the unit at its default 32-bit width. At that width the 5-bit indirect field, the 32-minus-n convention for indirect left shifts and the funnel example with its known value can all be checked directly against literal constants. A bench model tracks the previous-A field, the carry and the two-deep sign history. This makes back-to-back dependent sequences checkable, such as a carry chain, conditional adds that follow signs of both polarities, and indirect shifts issued after idle gaps.

// File: rtl/shalu_pkg.sv
`timescale 1ns/1ps
package shalu_pkg;

  typedef enum logic [3:0] {
    OP_PASSB  = 4'd0,
    OP_NOTB   = 4'd1,
    OP_ADD    = 4'd2,
    OP_ADDC   = 4'd3,
    OP_ADD8   = 4'd4,
    OP_ADD16  = 4'd5,
    OP_SUB    = 4'd6,
    OP_RSUB   = 4'd7,
    OP_AND    = 4'd8,
    OP_ANDNA  = 4'd9,
    OP_ANDNB  = 4'd10,
    OP_OR     = 4'd11,
    OP_XOR    = 4'd12,
    OP_ADDIFS = 4'd13
  } alu_op_e;

  typedef enum logic [2:0] {
    SH_NONE = 3'd0,
    SH_LSL  = 3'd1,
    SH_LSR  = 3'd2,
    SH_ROL  = 3'd3,
    SH_ROR  = 3'd4,
    SH_ILSL = 3'd5,
    SH_ILSR = 3'd6,
    SH_NOP7 = 3'd7
  } shf_mode_e;

  // Operations whose carry-out is meaningful; all others report 0.
  function automatic logic op_has_carry(input alu_op_e op);
    return (op == OP_ADD)  || (op == OP_ADDC) || (op == OP_ADD8) ||
           (op == OP_ADD16) || (op == OP_SUB) || (op == OP_RSUB);
  endfunction

endpackage

// File: rtl/shalu_rotshift.sv
`timescale 1ns/1ps
// B-operand shifter: one left rotator plus a mask covers all shift kinds.
module shalu_rotshift
  import shalu_pkg::*;
#(
  parameter int W  = 32,
  localparam int SW = $clog2(W)
) (
  input  logic [W-1:0]  din,
  input  shf_mode_e     mode,
  input  logic [SW-1:0] fixed_amt,
  input  logic [SW-1:0] ind_field,
  output logic [W-1:0]  dout
);

  logic [SW-1:0] amt;
  logic [SW-1:0] rl_amt;
  logic [W-1:0]  keep_mask;
  logic          is_right;

  function automatic logic [SW-1:0] negate_amt(input logic [SW-1:0] n);
    return ~n + 1'b1;
  endfunction

  always_comb begin
    amt       = '0;
    is_right  = 1'b0;
    keep_mask = {W{1'b1}};
    unique case (mode)
      SH_LSL:  begin amt = fixed_amt;              keep_mask = {W{1'b1}} << amt; end
      SH_LSR:  begin amt = fixed_amt; is_right = 1'b1; keep_mask = {W{1'b1}} >> amt; end
      SH_ROL:  begin amt = fixed_amt; end
      SH_ROR:  begin amt = fixed_amt; is_right = 1'b1; end
      SH_ILSL: begin amt = negate_amt(ind_field);  keep_mask = {W{1'b1}} << amt; end
      SH_ILSR: begin amt = ind_field; is_right = 1'b1; keep_mask = {W{1'b1}} >> amt; end
      default: begin amt = '0; end
    endcase
    rl_amt = is_right ? negate_amt(amt) : amt;
  end

  logic [W-1:0] stg [SW+1];
  assign stg[0] = din;

  for (genvar k = 0; k < SW; k++) begin : g_stage
    localparam int STEP = 1 << k;
    assign stg[k+1] = rl_amt[k] ? ((stg[k] << STEP) | (stg[k] >> (W - STEP))) : stg[k];
  end

  assign dout = stg[SW] & keep_mask;

endmodule

// File: rtl/shalu_arith.sv
`timescale 1ns/1ps
// Combinational ALU operation on A and the shifted B.
module shalu_arith
  import shalu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_e      op,
  input  logic         carry_in,
  input  logic         sign_old,
  output logic [W-1:0] res,
  output logic         cout
);

  localparam int HALF = (W >= 16) ? 16 : W;
  localparam int BYTE = (W >= 8) ? 8 : W;

  function automatic logic [W:0] add3(input logic [W-1:0] x, input logic [W-1:0] y,
                                      input logic ci);
    return {1'b0, x} + {1'b0, y} + {{W{1'b0}}, ci};
  endfunction

  function automatic logic [W-1:0] low_bits(input logic [W-1:0] x, input int n);
    return x & ~({W{1'b1}} << n);
  endfunction

  logic [W:0] sum;

  always_comb begin
    sum = '0;
    res = b;
    unique case (op)
      OP_PASSB:  res = b;
      OP_NOTB:   res = ~b;
      OP_ADD:    begin sum = add3(a, b, 1'b0);                res = sum[W-1:0]; end
      OP_ADDC:   begin sum = add3(a, b, carry_in);            res = sum[W-1:0]; end
      OP_ADD8:   begin sum = add3(a, low_bits(b, BYTE), 1'b0); res = sum[W-1:0]; end
      OP_ADD16:  begin sum = add3(a, low_bits(b, HALF), 1'b0); res = sum[W-1:0]; end
      OP_SUB:    begin sum = add3(a, ~b, 1'b1);               res = sum[W-1:0]; end
      OP_RSUB:   begin sum = add3(b, ~a, 1'b1);               res = sum[W-1:0]; end
      OP_AND:    res = a & b;
      OP_ANDNA:  res = ~a & b;
      OP_ANDNB:  res = a & ~b;
      OP_OR:     res = a | b;
      OP_XOR:    res = a ^ b;
      OP_ADDIFS: begin
        sum = add3(a, b, 1'b0);
        res = sign_old ? sum[W-1:0] : b;
      end
      default:   res = b;
    endcase
    cout = op_has_carry(op) ? sum[W] : 1'b0;
  end

endmodule

// File: rtl/shalu_funnel.sv
`timescale 1ns/1ps
// Double-word right shift keeping the low word.
module shalu_funnel #(
  parameter int W  = 32,
  localparam int SW = $clog2(W)
) (
  input  logic [W-1:0]  hi,
  input  logic [W-1:0]  lo,
  input  logic [SW-1:0] amt,
  output logic [W-1:0]  dout
);

  function automatic logic [W-1:0] funnel_low(input logic [W-1:0] h, input logic [W-1:0] l,
                                              input logic [SW-1:0] n);
    logic [2*W-1:0] cat;
    cat = {h, l} >> n;
    return cat[W-1:0];
  endfunction

  assign dout = funnel_low(hi, lo, amt);

endmodule

// File: rtl/shalu_ccstate.sv
`timescale 1ns/1ps
// Condition codes plus the history that later instructions consume.
module shalu_ccstate #(
  parameter int W  = 32,
  localparam int SW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          issue,
  input  logic          new_sign,
  input  logic          new_zero,
  input  logic          new_cout,
  input  logic [SW-1:0] a_low,
  output logic          cc_sign,
  output logic          cc_zero,
  output logic          cc_cout,
  output logic          sign_two_back,
  output logic [SW-1:0] prev_a_field
);

  logic [1:0] sign_hist;

  always_ff @(posedge clk) begin
    if (rst) begin
      sign_hist    <= '0;
      cc_zero      <= 1'b0;
      cc_cout      <= 1'b0;
      prev_a_field <= '0;
    end else if (issue) begin
      sign_hist    <= {sign_hist[0], new_sign};
      cc_zero      <= new_zero;
      cc_cout      <= new_cout;
      prev_a_field <= a_low;
    end
  end

  assign cc_sign       = sign_hist[0];
  assign sign_two_back = sign_hist[1];

endmodule

// File: rtl/shift_alu_unit.sv
`timescale 1ns/1ps
module shift_alu_unit
  import shalu_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int SW = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue_valid,
  input  logic              funnel_en,
  input  logic [3:0]        alu_sel,
  input  logic [2:0]        shf_mode,
  input  logic [SW-1:0]     shf_amt,
  input  logic [DATA_W-1:0] a_opnd,
  input  logic [DATA_W-1:0] b_opnd,
  output logic [DATA_W-1:0] result,
  output logic              result_valid,
  output logic              cc_sign,
  output logic              cc_zero,
  output logic              cc_cout
);

  alu_op_e   op_e;
  shf_mode_e mode_e;
  assign op_e   = alu_op_e'(alu_sel);
  assign mode_e = shf_mode_e'(shf_mode);

  // Named internal events, visible to the bound checker.
  logic [DATA_W-1:0] b_shf;
  logic [DATA_W-1:0] alu_res;
  logic              alu_cout;
  logic [DATA_W-1:0] fun_res;
  logic [SW-1:0]     fun_amt;
  logic [SW-1:0]     ind_field;
  logic              sign_two_back;
  logic [DATA_W-1:0] next_res;
  logic              next_cout;

  shalu_rotshift #(.W(DATA_W)) u_shift (
    .din       (b_opnd),
    .mode      (mode_e),
    .fixed_amt (shf_amt),
    .ind_field (ind_field),
    .dout      (b_shf)
  );

  shalu_arith #(.W(DATA_W)) u_arith (
    .a        (a_opnd),
    .b        (b_shf),
    .op       (op_e),
    .carry_in (cc_cout),
    .sign_old (sign_two_back),
    .res      (alu_res),
    .cout     (alu_cout)
  );

  assign fun_amt = (mode_e == SH_ILSR) ? ind_field : shf_amt;

  shalu_funnel #(.W(DATA_W)) u_funnel (
    .hi   (a_opnd),
    .lo   (b_opnd),
    .amt  (fun_amt),
    .dout (fun_res)
  );

  assign next_res  = funnel_en ? fun_res : alu_res;
  assign next_cout = funnel_en ? 1'b0 : alu_cout;

  shalu_ccstate #(.W(DATA_W)) u_cc (
    .clk           (clk),
    .rst           (rst),
    .issue         (issue_valid),
    .new_sign      (next_res[DATA_W-1]),
    .new_zero      (next_res == '0),
    .new_cout      (next_cout),
    .a_low         (a_opnd[SW-1:0]),
    .cc_sign       (cc_sign),
    .cc_zero       (cc_zero),
    .cc_cout       (cc_cout),
    .sign_two_back (sign_two_back),
    .prev_a_field  (ind_field)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result       <= '0;
      result_valid <= 1'b0;
    end else begin
      result_valid <= issue_valid;
      if (issue_valid) result <= next_res;
    end
  end

endmodule

// File: rtl/shalu_chk.sv
`timescale 1ns/1ps
module shalu_chk #(
  parameter int W  = 32,
  localparam int SW = $clog2(W)
) (
  input logic          clk,
  input logic          rst,
  input logic          issue_valid,
  input logic          funnel_en,
  input logic [3:0]    alu_sel,
  input logic [W-1:0]  a_opnd,
  input logic [W-1:0]  result,
  input logic          result_valid,
  input logic          cc_sign,
  input logic          cc_zero,
  input logic          cc_cout,
  input logic [W-1:0]  b_shf,
  input logic [SW-1:0] ind_field,
  input logic          sign_two_back
);

  assert_zero_flag_R12: assert property (@(posedge clk) disable iff (rst)
    result_valid |-> (cc_zero == (result == '0)));

  assert_sign_flag_R12: assert property (@(posedge clk) disable iff (rst)
    result_valid |-> (cc_sign == result[W-1]));

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !issue_valid |=> ($stable(result) && $stable(cc_sign) && $stable(cc_zero)
                      && $stable(cc_cout) && !result_valid));

  assert_no_carry_R7: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && (funnel_en || alu_sel < 4'd2 || alu_sel > 4'd7)) |=> !cc_cout);

  assert_ind_field_R10: assert property (@(posedge clk) disable iff (rst)
    issue_valid |=> (ind_field == $past(a_opnd[SW-1:0])));

  assert_history_hold_R13: assert property (@(posedge clk) disable iff (rst)
    !issue_valid |=> ($stable(ind_field) && $stable(sign_two_back)));

  assert_ifsign_pass_R8: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && !funnel_en && alu_sel == 4'd13 && !sign_two_back)
      |=> (result == $past(b_shf)));

  assert_sub_equal_R6: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && !funnel_en && alu_sel == 4'd6 && a_opnd == b_shf)
      |=> (cc_zero && cc_cout));

endmodule

bind shift_alu_unit shalu_chk #(.W(DATA_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .issue_valid   (issue_valid),
  .funnel_en     (funnel_en),
  .alu_sel       (alu_sel),
  .a_opnd        (a_opnd),
  .result        (result),
  .result_valid  (result_valid),
  .cc_sign       (cc_sign),
  .cc_zero       (cc_zero),
  .cc_cout       (cc_cout),
  .b_shf         (b_shf),
  .ind_field     (ind_field),
  .sign_two_back (sign_two_back)
);

// File: tb/shift_alu_unit_tb.sv
`timescale 1ns/1ps
module shift_alu_unit_tb;

  logic        clk = 1'b0;
  logic        rst;
  logic        issue_valid;
  logic        funnel_en;
  logic [3:0]  alu_sel;
  logic [2:0]  shf_mode;
  logic [4:0]  shf_amt;
  logic [31:0] a_opnd, b_opnd;
  logic [31:0] result;
  logic        result_valid, cc_sign, cc_zero, cc_cout;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // bench model state
  logic [4:0] m_prev;
  logic       m_s1, m_s2, m_cy;
  logic [31:0] last_exp;

  always #10 clk = ~clk;

  shift_alu_unit u_dut (
    .clk(clk), .rst(rst), .issue_valid(issue_valid), .funnel_en(funnel_en),
    .alu_sel(alu_sel), .shf_mode(shf_mode), .shf_amt(shf_amt),
    .a_opnd(a_opnd), .b_opnd(b_opnd), .result(result), .result_valid(result_valid),
    .cc_sign(cc_sign), .cc_zero(cc_zero), .cc_cout(cc_cout)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] m_shl(input logic [31:0] x, input int n);
    logic [31:0] o;
    o = '0;
    for (int i = 0; i < 32; i++) if (i + n < 32) o[i+n] = x[i];
    return o;
  endfunction
  function automatic logic [31:0] m_shr(input logic [31:0] x, input int n);
    logic [31:0] o;
    o = '0;
    for (int i = 0; i < 32; i++) if (i - n >= 0) o[i-n] = x[i];
    return o;
  endfunction
  function automatic logic [31:0] m_rol(input logic [31:0] x, input int n);
    logic [31:0] o;
    o = '0;
    for (int i = 0; i < 32; i++) o[(i+n)%32] = x[i];
    return o;
  endfunction

  // Issue one instruction, predict with the model, check one cycle later.
  task automatic do_issue(input string req, input logic [3:0] op, input logic [2:0] md,
                          input logic [4:0] amt, input logic fn,
                          input logic [31:0] a, input logic [31:0] b);
    logic [31:0] bs, r;
    logic c;
    longint s;
    int n;
    case (md)
      3'd1: bs = m_shl(b, amt);
      3'd2: bs = m_shr(b, amt);
      3'd3: bs = m_rol(b, amt);
      3'd4: bs = m_rol(b, (32 - amt) % 32);
      3'd5: bs = m_shl(b, (32 - m_prev) % 32);
      3'd6: bs = m_shr(b, m_prev);
      default: bs = b;
    endcase
    c = 1'b0;
    if (fn) begin
      n = (md == 3'd6) ? int'(m_prev) : int'(amt);
      for (int i = 0; i < 32; i++) r[i] = (i + n < 32) ? b[i+n] : a[i+n-32];
    end else begin
      case (op)
        4'd1:  r = ~bs;
        4'd2:  begin s = longint'(a) + longint'(bs); r = s[31:0]; c = s[32]; end
        4'd3:  begin s = longint'(a) + longint'(bs) + longint'(m_cy); r = s[31:0]; c = s[32]; end
        4'd4:  begin s = longint'(a) + longint'(bs & 32'hFF); r = s[31:0]; c = s[32]; end
        4'd5:  begin s = longint'(a) + longint'(bs & 32'hFFFF); r = s[31:0]; c = s[32]; end
        4'd6:  begin r = a - bs; c = (a >= bs); end
        4'd7:  begin r = bs - a; c = (bs >= a); end
        4'd8:  r = a & bs;
        4'd9:  r = ~a & bs;
        4'd10: r = a & ~bs;
        4'd11: r = a | bs;
        4'd12: r = a ^ bs;
        4'd13: r = m_s2 ? a + bs : bs;
        default: r = bs;
      endcase
    end
    m_s2 = m_s1; m_s1 = r[31]; m_cy = c; m_prev = a[4:0];
    last_exp = r;
    alu_sel = op; shf_mode = md; shf_amt = amt; funnel_en = fn;
    a_opnd = a; b_opnd = b; issue_valid = 1'b1;
    @(negedge clk);
    chk(req, "result", result, r);
    chk("R12", "sign", {31'b0, cc_sign}, {31'b0, r[31]});
    chk("R12", "zero", {31'b0, cc_zero}, {31'b0, r == 32'b0});
    chk(req, "cout", {31'b0, cc_cout}, {31'b0, c});
    chk("R2", "valid", {31'b0, result_valid}, 32'd1);
    issue_valid = 1'b0;
  endtask

  task automatic t_reset;
    rst = 1'b1; issue_valid = 1'b1; funnel_en = 1'b0; alu_sel = 4'd2;
    shf_mode = 3'd0; shf_amt = 5'd0; a_opnd = 32'hFFFF_FFFF; b_opnd = 32'h1;
    repeat (3) @(negedge clk);
    chk("R1", "result", result, 32'b0);
    chk("R1", "codes", {29'b0, result_valid, cc_sign, cc_zero}, 32'b0);
    chk("R1", "cout", {31'b0, cc_cout}, 32'b0);
    m_prev = '0; m_s1 = 0; m_s2 = 0; m_cy = 0;
    rst = 1'b0; issue_valid = 1'b0;
    @(negedge clk);
    // R1: cleared carry and sign history seen through dependent ops
    do_issue("R1", 4'd3, 3'd0, 5'd0, 1'b0, 32'd1, 32'd1);
    chk("R1", "addc after reset", result, 32'd2);
    do_issue("R1", 4'd13, 3'd0, 5'd0, 1'b0, 32'd100, 32'd7);
    chk("R1", "ifsign after reset", result, 32'd7);
  endtask

  task automatic t_logic;
    logic [31:0] a = 32'hF0F0_1234, b = 32'h0FF0_5678;
    for (int op = 8; op <= 12; op++) do_issue("R3", 4'(op), 3'd0, 5'd0, 1'b0, a, b);
    do_issue("R3", 4'd0, 3'd0, 5'd0, 1'b0, a, b);
    chk("R3", "pass B", result, b);
    do_issue("R3", 4'd1, 3'd0, 5'd0, 1'b0, a, b);
    chk("R3", "invert B", result, ~b);
    do_issue("R3", 4'd14, 3'd0, 5'd0, 1'b0, a, b);
    do_issue("R3", 4'd15, 3'd0, 5'd0, 1'b0, a, 32'h0);
    // R7: logic op after a carry-producing add leaves cout 0
    do_issue("R4", 4'd2, 3'd0, 5'd0, 1'b0, 32'hFFFF_FFFF, 32'd2);
    do_issue("R7", 4'd11, 3'd0, 5'd0, 1'b0, a, b);
    chk("R7", "cout after OR", {31'b0, cc_cout}, 32'd0);
  endtask

  task automatic t_adds;
    do_issue("R4", 4'd2, 3'd0, 5'd0, 1'b0, 32'h7FFF_FFFF, 32'd1);
    do_issue("R4", 4'd2, 3'd0, 5'd0, 1'b0, 32'hFFFF_FFFF, 32'd1);
    chk("R4", "wrap to zero", result, 32'd0);
    do_issue("R5", 4'd3, 3'd0, 5'd0, 1'b0, 32'd5, 32'd6);
    chk("R5", "carry chained", result, 32'd12);
    do_issue("R4", 4'd4, 3'd0, 5'd0, 1'b0, 32'h1000_0000, 32'hABCD_EF12);
    chk("R4", "byte add", result, 32'h1000_0012);
    do_issue("R4", 4'd5, 3'd0, 5'd0, 1'b0, 32'hFFFF_0001, 32'hABCD_FFFF);
    do_issue("R5", 4'd3, 3'd0, 5'd0, 1'b0, 32'hFFFF_FFFF, 32'd0);
  endtask

  task automatic t_sub;
    do_issue("R6", 4'd6, 3'd0, 5'd0, 1'b0, 32'd10, 32'd3);
    do_issue("R6", 4'd6, 3'd0, 5'd0, 1'b0, 32'd3, 32'd10);
    chk("R6", "borrow cout", {31'b0, cc_cout}, 32'd0);
    do_issue("R6", 4'd6, 3'd0, 5'd0, 1'b0, 32'h55, 32'h55);
    chk("R6", "equal cout", {31'b0, cc_cout}, 32'd1);
    do_issue("R6", 4'd7, 3'd0, 5'd0, 1'b0, 32'd3, 32'd10);
    do_issue("R6", 4'd7, 3'd0, 5'd0, 1'b0, 32'd10, 32'd3);
  endtask

  task automatic t_shifts;
    logic [31:0] b = 32'h8123_4567;
    for (int m = 1; m <= 4; m++) begin
      do_issue("R9", 4'd0, 3'(m), 5'd4, 1'b0, 32'd0, b);
      do_issue("R9", 4'd0, 3'(m), 5'd31, 1'b0, 32'd0, b);
      do_issue("R9", 4'd0, 3'(m), 5'd0, 1'b0, 32'd0, b);
    end
    do_issue("R9", 4'd0, 3'd3, 5'd8, 1'b0, 32'd0, 32'h1122_3344);
    chk("R9", "rotate left 8", result, 32'h2233_4411);
    do_issue("R9", 4'd2, 3'd1, 5'd16, 1'b0, 32'd1, 32'd3);
    chk("R9", "shift then add", result, 32'h0003_0001);
    do_issue("R9", 4'd0, 3'd7, 5'd9, 1'b0, 32'd0, b);
  endtask

  task automatic t_indirect;
    do_issue("R10", 4'd0, 3'd0, 5'd0, 1'b0, 32'd3, 32'd0);
    do_issue("R10", 4'd0, 3'd5, 5'd0, 1'b0, 32'd3, 32'd1);
    chk("R10", "indirect left 29", result, 32'h2000_0000);
    do_issue("R10", 4'd0, 3'd6, 5'd0, 1'b0, 32'd0, 32'd8);
    chk("R10", "indirect right 3", result, 32'd1);
    do_issue("R10", 4'd0, 3'd5, 5'd0, 1'b0, 32'h20, 32'hDEAD_BEEF);
    chk("R10", "field 0 leaves B", result, 32'hDEAD_BEEF);
  endtask

  task automatic t_ifsign;
    do_issue("R8", 4'd0, 3'd0, 5'd0, 1'b0, 32'd0, 32'h8000_0000);
    do_issue("R8", 4'd0, 3'd0, 5'd0, 1'b0, 32'd0, 32'd1);
    do_issue("R8", 4'd13, 3'd0, 5'd0, 1'b0, 32'd10, 32'd20);
    chk("R8", "two-back sign set", result, 32'd30);
    do_issue("R8", 4'd13, 3'd0, 5'd0, 1'b0, 32'd10, 32'd20);
    chk("R8", "two-back sign clear", result, 32'd20);
  endtask

  task automatic t_funnel;
    do_issue("R11", 4'd2, 3'd0, 5'd12, 1'b1, 32'h8765_4321, 32'hFEDC_BA98);
    chk("R11", "funnel example", result, 32'h321F_EDCB);
    do_issue("R11", 4'd2, 3'd0, 5'd0, 1'b1, 32'h0000_0005, 32'h0);
    chk("R11", "funnel zero", {31'b0, cc_zero}, 32'd1);
    do_issue("R11", 4'd0, 3'd6, 5'd1, 1'b1, 32'hF000_000F, 32'h1234_5678);
    chk("R7", "funnel cout", {31'b0, cc_cout}, 32'd0);
  endtask

  task automatic t_idle;
    logic [31:0] held;
    do_issue("R13", 4'd0, 3'd0, 5'd0, 1'b0, 32'd7, 32'h8000_0001);
    held = result;
    a_opnd = 32'h1F; b_opnd = 32'h0; alu_sel = 4'd2;
    repeat (3) @(negedge clk);
    chk("R2", "held result", result, held);
    chk("R2", "valid low", {31'b0, result_valid}, 32'd0);
    do_issue("R13", 4'd0, 3'd6, 5'd0, 1'b0, 32'd0, 32'h80);
    chk("R13", "field kept over idle", result, 32'd1);
  endtask

  initial begin
    t_reset();
    t_logic();
    t_adds();
    t_sub();
    t_shifts();
    t_indirect();
    t_ifsign();
    t_funnel();
    t_idle();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule